// File: doc/BRIEF.md
# Block-Scaled FP4 Dequantizer

This block turns compressed 4-bit floating-point tensor data back into FP32. Each input beat is one micro-block of sixteen 4-bit element codes packed into 64 bits, plus an 8-bit block scale in E4M3 format. A per-tensor FP32 scale sits in a small register that software loads. For each beat the block returns sixteen FP32 lanes, each equal to element × block scale × tensor scale.

The block scale and the tensor scale are first merged into one FP32 factor, rounded to nearest-even. Each of the sixteen lanes then multiplies its element by that factor, again with nearest-even rounding. Overflow goes to signed infinity and subnormal results are kept. A NaN scale poisons the whole block. Both sides use valid/ready handshakes. A three-stage pipeline takes one block per cycle while the consumer is ready and freezes as a whole when it is not.

Top module: `fp4blk_dequant`

## Requirements
- R1: Element i is taken from bits [4i+3:4i] of `in_elems` and drives `out_data[32i+31:32i]`. Bit 3 of a code is the sign. Magnitude codes 0..7 stand for 0, 0.5, 1, 1.5, 2, 3, 4 and 6. There are no special element codes.
- R2: The block scale is E4M3: bit 7 sign, bits 6:3 exponent with bias 7, bits 2:0 mantissa. Exponent 0 encodes subnormals with value m×2^-9.
- R3: The tensor scale register resets to 1.0 (0x3F800000) and is loaded from `ts_wdata` when `ts_we` is high and no beat is in flight. A beat accepted in the same cycle as the load still uses the old value. The next accepted beat uses the new one.
- R4: A tensor scale write made while any beat is in flight is dropped.
- R5: Block scale × tensor scale is rounded to nearest-even into FP32, and each element × that product is rounded the same way. Results in the subnormal range are produced with the same rounding.
- R6: A finite result too large for FP32 becomes infinity carrying the product's sign.
- R7: If the block scale is NaN (codes 0x7F, 0xFF) or the tensor scale is an FP32 NaN, all sixteen lanes read 0x7FC00000.
- R8: A zero element code (0x0 or 0x8) gives a zero whose sign is the XOR of the element sign and the combined scale sign, even when that scale is infinite.
- R9: A beat accepted at rising edge k appears on `out_valid`/`out_data` right after edge k+2, provided `out_ready` is high at edges k+1 and k+2. Cycles without `in_valid` leave bubbles in the same positions.
- R10: `in_ready` equals `out_ready`. While `out_ready` is low no stage moves and `out_valid`/`out_data` hold their values.
- R11: After synchronous reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_elems | input | 64 | Sixteen packed 4-bit element codes, lane 0 in the low nibble |
| in_bscale | input | 8 | E4M3 block scale for this beat |
| ts_we | input | 1 | Tensor scale write strobe |
| ts_wdata | input | 32 | New FP32 tensor scale |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer accepts the output block |
| out_data | output | 512 | Sixteen FP32 results, lane i at bits [32i+31:32i] |

## Verification
Each kind of fault in this block shows at the ports within three cycles of the beat that exposes it. A wrong combined scale corrupts all sixteen lanes of that beat in the same way. A wrong lane multiplier or rounding step shows only in the lanes whose element codes reach it. Ties, subnormal products and overflow to infinity are set up on purpose so that truncation or a missing saturation changes the last bit or the exponent field. A stale or corrupted tensor scale register stays hidden until the next accepted beat, so every scale write is followed by a beat whose expected lanes depend on which value was used. A stall fault shows as a valid beat that is lost, duplicated or altered while `out_ready` is low.

// File: rtl/fp4blk_pkg.sv
package fp4blk_pkg;

    localparam int LANES   = 16;
    localparam int ELEM_W  = 4;
    localparam int SCALE_W = 8;
    localparam int FP_W    = 32;
    localparam int PACK_W  = LANES * ELEM_W;
    localparam int OUT_W   = LANES * FP_W;

    localparam logic [FP_W-1:0] FP_QNAN = 32'h7FC0_0000;
    localparam logic [FP_W-1:0] FP_ONE  = 32'h3F80_0000;

    typedef logic [ELEM_W-1:0] elem_code_t;

    // first pipeline stage: decoded scales plus raw element codes
    typedef struct packed {
        logic                  vld;
        logic [FP_W-1:0]       bsc;
        logic [FP_W-1:0]       tsc;
        elem_code_t [LANES-1:0] elems;
    } stg_dec_t;

    // second pipeline stage: merged scale plus raw element codes
    typedef struct packed {
        logic                  vld;
        logic [FP_W-1:0]       csc;
        elem_code_t [LANES-1:0] elems;
    } stg_cmb_t;

    function automatic logic fp_is_nan(input logic [FP_W-1:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'h0);
    endfunction

    // 4-bit element code (sign + 3-bit magnitude) to exact FP32
    function automatic logic [FP_W-1:0] elem_to_fp32(input elem_code_t c);
        logic [30:0] mag;
        case (c[2:0])
            3'd0:    mag = 31'h0000_0000;
            3'd1:    mag = 31'h3F00_0000;
            3'd2:    mag = 31'h3F80_0000;
            3'd3:    mag = 31'h3FC0_0000;
            3'd4:    mag = 31'h4000_0000;
            3'd5:    mag = 31'h4040_0000;
            3'd6:    mag = 31'h4080_0000;
            default: mag = 31'h40C0_0000;
        endcase
        return {c[3], mag};
    endfunction

    // E4M3 code to exact FP32, subnormals normalised
    function automatic logic [FP_W-1:0] scale_to_fp32(input logic [SCALE_W-1:0] c);
        logic [3:0] ex;
        logic [2:0] mt;
        logic [3:0] msh;
        int         p;
        ex = c[6:3];
        mt = c[2:0];
        if (ex == 4'hF && mt == 3'h7) return FP_QNAN;
        if (ex != 4'h0) return {c[7], 8'(int'(ex) + 120), mt, 20'h0};
        if (mt == 3'h0) return {c[7], 31'h0};
        p = 0;
        for (int i = 0; i < 3; i++) if (mt[i]) p = i;
        msh = 4'({1'b0, mt} << (3 - p));
        return {c[7], 8'(118 + p), msh[2:0], 20'h0};
    endfunction

    // FP32 x FP32, round to nearest-even, overflow to infinity, subnormals kept
    function automatic logic [FP_W-1:0] fp32_mul(input logic [FP_W-1:0] a,
                                                 input logic [FP_W-1:0] b);
        logic        sgn, az, bz, ai, bi, guard, sticky, rnd;
        logic [23:0] sa, sb;
        logic [47:0] prod, norm;
        logic [71:0] ext;
        logic [30:0] mag;
        int          ex, lead, re, sh;
        sgn = a[31] ^ b[31];
        az  = (a[30:0] == 31'h0);
        bz  = (b[30:0] == 31'h0);
        ai  = (a[30:23] == 8'hFF) && (a[22:0] == 23'h0);
        bi  = (b[30:23] == 8'hFF) && (b[22:0] == 23'h0);
        if (fp_is_nan(a) || fp_is_nan(b) || (ai && bz) || (bi && az)) return FP_QNAN;
        if (ai || bi) return {sgn, 8'hFF, 23'h0};
        if (az || bz) return {sgn, 31'h0};
        sa   = {(a[30:23] != 8'h0), a[22:0]};
        sb   = {(b[30:23] != 8'h0), b[22:0]};
        ex   = ((a[30:23] == 8'h0) ? 1 : int'(a[30:23]))
             + ((b[30:23] == 8'h0) ? 1 : int'(b[30:23])) - 127;
        prod = 48'(sa) * 48'(sb);
        lead = 0;
        for (int i = 0; i < 48; i++) if (prod[i]) lead = i;
        re = ex + lead - 46;
        if (re >= 255) return {sgn, 8'hFF, 23'h0};
        if (re >= 1) begin
            norm   = prod << (47 - lead);
            mag    = {8'(re), norm[46:24]};
            guard  = norm[23];
            sticky = |norm[22:0];
        end else begin
            sh = 24 - ex;
            if (sh > 71) begin
                mag    = 31'h0;
                guard  = 1'b0;
                sticky = 1'b1;
            end else begin
                ext    = {prod, 24'h0} >> sh;
                mag    = {8'h00, ext[46:24]};
                guard  = ext[23];
                sticky = |ext[22:0];
            end
        end
        rnd = guard & (sticky | mag[0]);
        mag = mag + {30'h0, rnd};
        return {sgn, mag};
    endfunction

endpackage

// File: rtl/fp4blk_decode_stage.sv
module fp4blk_decode_stage
    import fp4blk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               in_valid,
    input  logic [PACK_W-1:0]  in_elems,
    input  logic [SCALE_W-1:0] in_bscale,
    input  logic [FP_W-1:0]    tscale,
    output stg_dec_t           dec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else if (en) begin
            dec_q.vld   <= in_valid;
            dec_q.bsc   <= scale_to_fp32(in_bscale);
            dec_q.tsc   <= tscale;
            dec_q.elems <= in_elems;
        end
    end

endmodule

// File: rtl/fp4blk_combine_stage.sv
module fp4blk_combine_stage
    import fp4blk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  stg_dec_t dec_q,
    output stg_cmb_t cmb_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmb_q <= '0;
        end else if (en) begin
            cmb_q.vld   <= dec_q.vld;
            cmb_q.csc   <= fp32_mul(dec_q.bsc, dec_q.tsc);
            cmb_q.elems <= dec_q.elems;
        end
    end

endmodule

// File: rtl/fp4blk_lane.sv
module fp4blk_lane
    import fp4blk_pkg::*;
(
    input  elem_code_t      code,
    input  logic [FP_W-1:0] scale,
    output logic [FP_W-1:0] result
);

    always_comb begin
        if (fp_is_nan(scale)) begin
            result = FP_QNAN;
        end else if (code[2:0] == 3'd0) begin
            result = {code[3] ^ scale[31], 31'h0};
        end else begin
            result = fp32_mul(elem_to_fp32(code), scale);
        end
    end

endmodule

// File: rtl/fp4blk_lane_stage.sv
module fp4blk_lane_stage
    import fp4blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  stg_cmb_t         cmb_q,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    logic [FP_W-1:0] lane_res [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fp4blk_lane u_lane (
            .code   (cmb_q.elems[g]),
            .scale  (cmb_q.csc),
            .result (lane_res[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_data[g*FP_W +: FP_W] <= '0;
            end else if (en) begin
                out_data[g*FP_W +: FP_W] <= lane_res[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (en) begin
            out_valid <= cmb_q.vld;
        end
    end

endmodule

// File: rtl/fp4blk_dequant.sv
module fp4blk_dequant
    import fp4blk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PACK_W-1:0]  in_elems,
    input  logic [SCALE_W-1:0] in_bscale,
    input  logic               ts_we,
    input  logic [FP_W-1:0]    ts_wdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OUT_W-1:0]   out_data
);

    logic            advance;
    logic            busy;
    logic [FP_W-1:0] tscale_q;
    stg_dec_t        dec_q;
    stg_cmb_t        cmb_q;

    // the whole pipeline moves together, only when the consumer takes data
    assign advance  = out_ready;
    assign in_ready = out_ready;
    assign busy     = dec_q.vld | cmb_q.vld | out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            tscale_q <= FP_ONE;
        end else if (ts_we && !busy) begin
            tscale_q <= ts_wdata;
        end
    end

    fp4blk_decode_stage u_dec (
        .clk       (clk),
        .rst       (rst),
        .en        (advance),
        .in_valid  (in_valid),
        .in_elems  (in_elems),
        .in_bscale (in_bscale),
        .tscale    (tscale_q),
        .dec_q     (dec_q)
    );

    fp4blk_combine_stage u_cmb (
        .clk   (clk),
        .rst   (rst),
        .en    (advance),
        .dec_q (dec_q),
        .cmb_q (cmb_q)
    );

    fp4blk_lane_stage u_lanes (
        .clk       (clk),
        .rst       (rst),
        .en        (advance),
        .cmb_q     (cmb_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/fp4blk_dequant_chk.sv
module fp4blk_dequant_chk
    import fp4blk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [PACK_W-1:0]  in_elems,
    input logic [SCALE_W-1:0] in_bscale,
    input logic               ts_we,
    input logic [FP_W-1:0]    ts_wdata,
    input logic               out_valid,
    input logic               out_ready,
    input logic [OUT_W-1:0]   out_data
);

    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !out_valid); // R11

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid); // R9

    AST_PIPE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && out_ready) ##1 out_ready ##1 out_ready |=> !out_valid); // R9

    AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[30:23] == 8'hFF && out_data[22:0] != 23'h0)
        |-> (out_data[31:0] == FP_QNAN)); // R7

endmodule

bind fp4blk_dequant fp4blk_dequant_chk u_chk (.*);

// File: tb/fp4blk_dequant_tb.sv
module fp4blk_dequant_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [63:0]  in_elems;
    logic [7:0]   in_bscale;
    logic         ts_we;
    logic [31:0]  ts_wdata;
    logic         out_valid;
    logic         out_ready;
    logic [511:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] exp_l [16];

    always #4 clk = ~clk;

    fp4blk_dequant u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_elems  (in_elems),
        .in_bscale (in_bscale),
        .ts_we     (ts_we),
        .ts_wdata  (ts_wdata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
        n_tests++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, expv);
        end
    endtask

    task automatic fill_exp(input logic [31:0] v);
        for (int i = 0; i < 16; i++) exp_l[i] = v;
    endtask

    task automatic write_ts(input logic [31:0] v);
        @(negedge clk);
        ts_we = 1'b1; ts_wdata = v;
        @(negedge clk);
        ts_we = 1'b0;
    endtask

    // send one beat with out_ready high, check the latency and every lane
    task automatic run_beat(input logic [63:0] el, input logic [7:0] bs,
                            input logic we, input logic [31:0] wd, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_elems = el; in_bscale = bs;
        ts_we = we; ts_wdata = wd; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; ts_we = 1'b0;
        chk({tag, " R9 valid after 1 edge"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        chk({tag, " R9 valid after 2 edges"}, 32'(out_valid), 32'd0);
        @(negedge clk);
        chk({tag, " R9 valid after 3 edges"}, 32'(out_valid), 32'd1);
        for (int i = 0; i < 16; i++)
            chk($sformatf("%s lane %0d", tag, i), out_data[i*32 +: 32], exp_l[i]);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R10 in_ready follows out_ready", 32'(in_ready), 32'(out_ready));
    endtask

    task automatic t_basic;
        // tensor scale still at its reset value of 1.0 (R3), block scale 1.0
        logic [31:0] mags [8] = '{32'h0, 32'h3F000000, 32'h3F800000, 32'h3FC00000,
                                  32'h40000000, 32'h40400000, 32'h40800000, 32'h40C00000};
        for (int i = 0; i < 8; i++) begin
            exp_l[i]     = mags[i];
            exp_l[i + 8] = mags[i] | 32'h80000000;
        end
        run_beat(64'hFEDC_BA98_7654_3210, 8'h38, 1'b0, 32'h0, "R1 R3 R8 basic map");
    endtask

    task automatic t_block_scale;
        fill_exp(32'h0);
        exp_l[0] = 32'h3B000000; exp_l[1] = 32'h3C400000; exp_l[2] = 32'h3A800000;
        run_beat(64'h0000_0000_0000_0172, 8'h01, 1'b0, 32'h0, "R2 subnormal scale");
        fill_exp(32'h80000000);
        exp_l[0] = 32'hC3E00000; exp_l[1] = 32'hC5280000; exp_l[2] = 32'h44280000;
        run_beat(64'h0000_0000_0000_0B72, 8'hFE, 1'b0, 32'h0, "R2 R8 max negative scale");
    endtask

    task automatic t_tensor_write;
        write_ts(32'h40000000);
        fill_exp(32'h0);
        exp_l[0] = 32'h40000000; exp_l[1] = 32'h41400000;
        // load of 4.0 in the same cycle as this beat: beat still sees 2.0
        run_beat(64'h0000_0000_0000_0072, 8'h38, 1'b1, 32'h40800000, "R3 same-cycle load");
        fill_exp(32'h0);
        exp_l[0] = 32'h40800000;
        run_beat(64'h0000_0000_0000_0002, 8'h38, 1'b0, 32'h0, "R3 next beat new scale");
    endtask

    task automatic t_rounding;
        write_ts(32'h3F800001);
        fill_exp(32'h0);
        exp_l[0] = 32'h3FC00002; exp_l[1] = 32'h40100002; exp_l[2] = 32'h40900002;
        run_beat(64'h0000_0000_0000_0532, 8'h3C, 1'b0, 32'h0, "R5 ties to even");
        write_ts(32'h00000001);
        fill_exp(32'h0);
        exp_l[0] = 32'h00000002; exp_l[1] = 32'h00000001; exp_l[2] = 32'h00000003;
        run_beat(64'h0000_0000_0000_0312, 8'h3C, 1'b0, 32'h0, "R5 subnormal tie");
        write_ts(32'h00800000);
        fill_exp(32'h0);
        exp_l[0] = 32'h00004000; exp_l[1] = 32'h00018000; exp_l[2] = 32'h00002000;
        run_beat(64'h0000_0000_0000_0172, 8'h01, 1'b0, 32'h0, "R5 subnormal product");
    endtask

    task automatic t_overflow;
        write_ts(32'h7F000000);
        fill_exp(32'h80000000);
        exp_l[0] = 32'hFF800000; exp_l[1] = 32'h7F800000;
        run_beat(64'h0000_0000_0000_00A2, 8'hFE, 1'b0, 32'h0, "R6 R8 infinite scale");
        fill_exp(32'h0);
        exp_l[0] = 32'h7F800000; exp_l[1] = 32'h7E800000; exp_l[2] = 32'hFF800000;
        run_beat(64'h0000_0000_0000_0F17, 8'h38, 1'b0, 32'h0, "R6 lane overflow");
    endtask

    task automatic t_nan;
        write_ts(32'h3F800000);
        fill_exp(32'h7FC00000);
        run_beat(64'hFEDC_BA98_7654_3210, 8'h7F, 1'b0, 32'h0, "R7 nan block 7F");
        run_beat(64'h1111_2222_3333_7777, 8'hFF, 1'b0, 32'h0, "R7 nan block FF");
        write_ts(32'hFF800001);
        run_beat(64'h0123_4567_89AB_CDEF, 8'h38, 1'b0, 32'h0, "R7 nan tensor");
    endtask

    task automatic t_stall;
        write_ts(32'h3F800000);
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_elems = 64'h2; in_bscale = 8'h38;
        chk("R10 in_ready low while stalled", 32'(in_ready), 32'd0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10 nothing emitted while stalled", 32'(out_valid), 32'd0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_elems = 64'h7;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 first of pair valid", 32'(out_valid), 32'd1);
        chk("R9 first of pair lane0", out_data[31:0], 32'h3F800000);
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 valid held", 32'(out_valid), 32'd1);
            chk("R10 data held", out_data[31:0], 32'h3F800000);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9 second of pair valid", 32'(out_valid), 32'd1);
        chk("R9 second of pair lane0", out_data[31:0], 32'h40C00000);
        @(negedge clk);
        chk("R9 bubble after pair", 32'(out_valid), 32'd0);
    endtask

    task automatic t_busy_write;
        write_ts(32'h3F800000);
        @(negedge clk);
        in_valid = 1'b1; in_elems = 64'h2; in_bscale = 8'h38; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        ts_we = 1'b1; ts_wdata = 32'h41000000;
        @(negedge clk);
        ts_we = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        fill_exp(32'h0);
        exp_l[0] = 32'h3F800000;
        run_beat(64'h0000_0000_0000_0002, 8'h38, 1'b0, 32'h0, "R4 busy write dropped");
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_elems = '0; in_bscale = '0;
        ts_we = 1'b0; ts_wdata = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_block_scale();
        t_tensor_write();
        t_rounding();
        t_overflow();
        t_nan();
        t_stall();
        t_busy_write();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule